// File: doc/BRIEF.md
# Capture/Compare Counter Array

This block holds a 16-bit counter that runs without stopping and a set of compare/capture channels that all watch it. Each channel has a mode byte. The mode byte makes the channel do one of several jobs. It can capture the count on an edge of its input pin. It can raise a flag when the count reaches a 16-bit value, which serves as a software timer. It can invert its output pin each time the count reaches that value. It can also drive an 8-bit pulse-width output from the low byte of the count.

The counter advances on a tick from one of four sources:
- the system clock divided by twelve;
- the system clock divided by four;
- an overflow pulse from a neighbouring timer;
- a synchronised external count pin.

A small byte-wide register bus sets up the block and reads it back. Channel flags and the counter overflow flag stay set until software clears them. An interrupt request is formed from the channel flags, gated by each channel's own enable bit.

The register map is split into groups of four byte addresses. Group 0 holds the global registers:
- offset 0 is control: bit 0 run, bit 1 stop-in-idle, bits 3:2 tick source;
- offset 1 is the counter low byte;
- offset 2 is the counter high byte;
- offset 3 is status: bit m is the flag of channel m, bit 7 is overflow.

Channel m uses group m+1:
- offset 0 is its mode byte;
- offset 1 is its compare/capture low byte;
- offset 2 is its compare/capture high byte.

Mode bits:
- bit 0: compare enable;
- bit 1: match;
- bit 2: toggle;
- bit 3: pulse-width;
- bit 4: rising-edge capture;
- bit 5: falling-edge capture;
- bit 6: interrupt enable.

Top module: `cap_cmp_array`

## Requirements
- R1: After reset the counter, every mode byte, every compare byte, all channel flags, the overflow flag, every output pin and the interrupt request are zero.
- R2: The tick source field in control bits 3:2 selects the counter's tick: 0 is clock/12, 1 is clock/4, 2 is each cycle the timer-overflow input is high, and 3 is each synchronised rising edge of the external count pin.
- R3: The counter holds when control bit 0 (run) is 0. It also holds when control bit 1 is 1 and the idle input is high. With control bit 1 at 0 it keeps counting in idle.
- R4: The counter bytes can be written at offsets 1 and 2. A tick at 0xFFFF wraps it to 0x0000 and sets the overflow flag (status bit 7). That flag stays set until a write to status has bit 7 set.
- R5: With mode bit 4 (rising) and/or bit 5 (falling) set, an edge of that polarity on the channel's synchronised capture pin copies the counter into the channel's compare bytes and sets its flag. An edge of a polarity that is not enabled changes nothing.
- R6: With mode bits 0 and 1 both set, the channel flag is set when the counter advances onto the 16-bit compare value. With bit 1 clear, no flag is raised.
- R7: With mode bits 0, 1 and 2 set, the channel's output pin inverts on each match.
- R8: With mode bits 0 and 3 set, the output pin is high exactly when the counter low byte is greater than or equal to the compare low byte. The compare low byte is reloaded from the compare high byte when a tick takes the counter low byte from 0xFF to 0x00.
- R9: Channel flags stay set until a status write has a 1 in the channel's bit. A 0 bit leaves the flag alone.
- R10: The interrupt request is high exactly when some channel has its flag set and its mode bit 6 set.
- R11: Writing a channel's compare low byte clears its mode bit 0. Writing the compare high byte sets it.
- R12: Control and mode registers read back what was written; mode bit 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| idleMode | input | 1 | Device idle indication |
| tmr0Ovf | input | 1 | Neighbour timer overflow pulse (tick source 2) |
| extCount | input | 1 | External count pin (tick source 3) |
| capIn | input | NUM_MOD | Per-channel capture pins |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte address |
| wrData | input | DATA_W | Register write data |
| rdData | output | DATA_W | Register read data (combinational) |
| cexOut | output | NUM_MOD | Per-channel output pins |
| modFlag | output | NUM_MOD | Per-channel flags |
| ovfFlag | output | 1 | Counter overflow flag |
| intReq | output | 1 | Gated interrupt request |

## Verification
The counter is driven from each tick source over fixed windows, so that a wrong divider or a wrong source select gives a count that differs from the expected one.

Capture is tried with rising, falling and disabled polarities. This shows whether edge polarity is decoded per bit and whether a captured value is the frozen count.

Matches are produced by stepping the counter onto the compare value one tick at a time, both with and without the match bit. This tells a real match apart from a stale equality.

The pulse-width output is probed on both sides of its threshold, before and after a low-byte rollover. This shows whether a duty change waits for the reload.

// File: rtl/cca_pkg.sv
package cca_pkg;
  localparam int MOD_SEL_W = 3;
  localparam int MODE_W    = 7;

  // mode byte bit positions
  localparam int MB_CMPEN = 0;
  localparam int MB_MATCH = 1;
  localparam int MB_TOG   = 2;
  localparam int MB_PWM   = 3;
  localparam int MB_CAPP  = 4;
  localparam int MB_CAPN  = 5;
  localparam int MB_INTEN = 6;

  typedef enum logic [1:0] {
    SRC_DIV12 = 2'd0,
    SRC_DIV4  = 2'd1,
    SRC_TMR0  = 2'd2,
    SRC_EXT   = 2'd3
  } clkSrcE;

  // strobes from control to datapath
  typedef struct packed {
    logic                 cntTick;
    logic                 wrCntLo;
    logic                 wrCntHi;
    logic                 wrStat;
    logic                 wrMod;
    logic                 selGlobal;
    logic                 selMod;
    logic [1:0]           field;
    logic [MOD_SEL_W-1:0] modSel;
  } ccaStrobeT;
endpackage

// File: rtl/cca_ctrl.sv
module cca_ctrl
  import cca_pkg::*;
#(
  parameter int NUM_MOD  = 5,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int PRE_DIV  = 12,
  parameter int FAST_DIV = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               idleMode,
  input  logic               tmr0Ovf,
  input  logic               extCount,
  input  logic [NUM_MOD-1:0] capIn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output ccaStrobeT          strobes,
  output logic [NUM_MOD-1:0] capRise,
  output logic [NUM_MOD-1:0] capFall,
  output logic [DATA_W-1:0]  ctrlReg
);
  localparam int PRE_W = $clog2(PRE_DIV);
  localparam int GRP_W = ADDR_W - 2;

  logic [PRE_W-1:0] preCnt;
  logic             preWrap;
  logic             fastPulse;
  logic [2:0]       extSh;
  logic             extRise;
  logic             runQ;
  logic             idleStopQ;
  clkSrcE           srcQ;
  logic             srcPulse;
  logic [GRP_W-1:0] grp;
  logic [1:0]       field;
  logic             isGlobal;
  logic             isMod;

  // free-running prescaler shared by both divided sources
  assign preWrap   = (preCnt == PRE_W'(PRE_DIV - 1));
  assign fastPulse = ((preCnt % PRE_W'(FAST_DIV)) == PRE_W'(FAST_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rstN)        preCnt <= '0;
    else if (preWrap) preCnt <= '0;
    else              preCnt <= preCnt + 1'b1;
  end

  // external count synchroniser and edge detect
  always_ff @(posedge clk) begin
    if (!rstN) extSh <= '0;
    else       extSh <= {extSh[1:0], extCount};
  end
  assign extRise = extSh[1] & ~extSh[2];

  // capture pin synchronisers
  for (genvar m = 0; m < NUM_MOD; m++) begin : g_capSync
    logic [2:0] capSh;
    always_ff @(posedge clk) begin
      if (!rstN) capSh <= '0;
      else       capSh <= {capSh[1:0], capIn[m]};
    end
    assign capRise[m] = capSh[1] & ~capSh[2];
    assign capFall[m] = ~capSh[1] & capSh[2];
  end

  // address decode
  assign grp      = addr[ADDR_W-1:2];
  assign field    = addr[1:0];
  assign isGlobal = (grp == '0);
  assign isMod    = !isGlobal && (grp <= GRP_W'(NUM_MOD));

  // control register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ      <= 1'b0;
      idleStopQ <= 1'b0;
      srcQ      <= SRC_DIV12;
    end else if (wrEn && isGlobal && field == 2'd0) begin
      runQ      <= wrData[0];
      idleStopQ <= wrData[1];
      srcQ      <= clkSrcE'(wrData[3:2]);
    end
  end

  always_comb begin
    ctrlReg      = '0;
    ctrlReg[0]   = runQ;
    ctrlReg[1]   = idleStopQ;
    ctrlReg[3:2] = srcQ;
  end

  always_comb begin
    unique case (srcQ)
      SRC_DIV12: srcPulse = preWrap;
      SRC_DIV4:  srcPulse = fastPulse;
      SRC_TMR0:  srcPulse = tmr0Ovf;
      SRC_EXT:   srcPulse = extRise;
    endcase
  end

  always_comb begin
    strobes           = '0;
    strobes.cntTick   = runQ && !(idleStopQ && idleMode) && srcPulse;
    strobes.wrCntLo   = wrEn && isGlobal && field == 2'd1;
    strobes.wrCntHi   = wrEn && isGlobal && field == 2'd2;
    strobes.wrStat    = wrEn && isGlobal && field == 2'd3;
    strobes.wrMod     = wrEn && isMod;
    strobes.selGlobal = isGlobal;
    strobes.selMod    = isMod;
    strobes.field     = field;
    strobes.modSel    = MOD_SEL_W'(grp - GRP_W'(1));
  end

  // R2: selecting the external source, a tick only follows a synchronised rise
  p_ext_edge_r2: assert property (@(posedge clk) disable iff (!rstN)
    (srcQ == SRC_EXT && strobes.cntTick) |-> (extSh[1] && !extSh[2]));
endmodule

// File: rtl/cca_slice.sv
module cca_slice
  import cca_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              tick,
  input  logic              tickSeen,
  input  logic              wrMode,
  input  logic              wrLo,
  input  logic              wrHi,
  input  logic [DATA_W-1:0] wrData,
  input  logic              capRise,
  input  logic              capFall,
  input  logic              clrFlag,
  output logic [MODE_W-1:0] modeQ,
  output logic [CNT_W-1:0]  cmpQ,
  output logic              flagQ,
  output logic              cexOut,
  output logic              intReq
);
  logic matchEvt;
  logic capEvt;
  logic pwmAct;
  logic loRoll;
  logic togQ;

  assign matchEvt = tickSeen && modeQ[MB_CMPEN] && modeQ[MB_MATCH] && (cnt == cmpQ);
  assign capEvt   = (capRise && modeQ[MB_CAPP]) || (capFall && modeQ[MB_CAPN]);
  assign pwmAct   = modeQ[MB_PWM] && modeQ[MB_CMPEN];
  assign loRoll   = tick && (cnt[DATA_W-1:0] == '1);

  always_ff @(posedge clk) begin
    if (!rstN)       modeQ <= '0;
    else if (wrMode) modeQ <= wrData[MODE_W-1:0];
    else if (wrLo)   modeQ[MB_CMPEN] <= 1'b0;
    else if (wrHi)   modeQ[MB_CMPEN] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpQ <= '0;
    end else if (wrLo || wrHi) begin
      if (wrLo) cmpQ[DATA_W-1:0]     <= wrData;
      if (wrHi) cmpQ[CNT_W-1:DATA_W] <= wrData;
    end else if (capEvt) begin
      cmpQ <= cnt;
    end else if (pwmAct && loRoll) begin
      cmpQ[DATA_W-1:0] <= cmpQ[CNT_W-1:DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   flagQ <= 1'b0;
    else if (matchEvt || capEvt) flagQ <= 1'b1;
    else if (clrFlag)            flagQ <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                            togQ <= 1'b0;
    else if (matchEvt && modeQ[MB_TOG])   togQ <= ~togQ;
  end

  assign cexOut = pwmAct ? (cnt[DATA_W-1:0] >= cmpQ[DATA_W-1:0]) : togQ;
  assign intReq = flagQ && modeQ[MB_INTEN];

  // R5: an enabled edge freezes the count into the compare bytes
  p_cap_copy_r5: assert property (@(posedge clk) disable iff (!rstN)
    (capEvt && !wrLo && !wrHi) |=> (cmpQ == $past(cnt)));
  // R6: a match always leaves the flag set
  p_match_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    matchEvt |=> flagQ);
  // R7: toggle mode inverts the pin on a match
  p_toggle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (matchEvt && modeQ[MB_TOG] && !pwmAct && !wrMode && !wrLo) |=> (cexOut != $past(cexOut)));
  // R8: low compare byte is reloaded on low-byte rollover
  p_pwm_reload_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pwmAct && loRoll && !wrLo && !wrHi && !capEvt) |=>
      (cmpQ[DATA_W-1:0] == $past(cmpQ[CNT_W-1:DATA_W])));
  // R9: a flag only goes away by an explicit clear
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !clrFlag) |=> flagQ);
  // R11: low-byte write disarms compare
  p_lo_disarm_r11: assert property (@(posedge clk) disable iff (!rstN)
    (wrLo && !wrMode) |=> !modeQ[MB_CMPEN]);
endmodule

// File: rtl/cca_datapath.sv
module cca_datapath
  import cca_pkg::*;
#(
  parameter int NUM_MOD = 5,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ccaStrobeT          strobes,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_MOD-1:0] capRise,
  input  logic [NUM_MOD-1:0] capFall,
  input  logic [DATA_W-1:0]  ctrlReg,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_MOD-1:0] cexOut,
  output logic [NUM_MOD-1:0] modFlag,
  output logic               ovfFlag,
  output logic               intReq
);
  localparam int CNT_W   = 2 * DATA_W;
  localparam int OVF_BIT = DATA_W - 1;

  logic [CNT_W-1:0]  cntQ;
  logic              ovfQ;
  logic              tickSeen;
  logic              cntWr;
  logic              tick;
  logic [MODE_W-1:0] modeArr [NUM_MOD];
  logic [CNT_W-1:0]  cmpArr  [NUM_MOD];
  logic [NUM_MOD-1:0] intVec;
  logic [DATA_W-1:0] statRd;

  assign tick  = strobes.cntTick;
  assign cntWr = strobes.wrCntLo || strobes.wrCntHi;

  always_ff @(posedge clk) begin
    if (!rstN)                cntQ <= '0;
    else if (strobes.wrCntLo) cntQ[DATA_W-1:0] <= wrData;
    else if (strobes.wrCntHi) cntQ[CNT_W-1:DATA_W] <= wrData;
    else if (tick)            cntQ <= cntQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfQ     <= 1'b0;
      tickSeen <= 1'b0;
    end else begin
      tickSeen <= tick && !cntWr;
      if (tick && !cntWr && cntQ == '1)             ovfQ <= 1'b1;
      else if (strobes.wrStat && wrData[OVF_BIT])   ovfQ <= 1'b0;
    end
  end

  for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
    logic hit;
    assign hit = strobes.wrMod && (strobes.modSel == MOD_SEL_W'(m));
    cca_slice #(.DATA_W(DATA_W)) u_slice (
      .clk      (clk),
      .rstN     (rstN),
      .cnt      (cntQ),
      .tick     (tick && !cntWr),
      .tickSeen (tickSeen),
      .wrMode   (hit && strobes.field == 2'd0),
      .wrLo     (hit && strobes.field == 2'd1),
      .wrHi     (hit && strobes.field == 2'd2),
      .wrData   (wrData),
      .capRise  (capRise[m]),
      .capFall  (capFall[m]),
      .clrFlag  (strobes.wrStat && wrData[m]),
      .modeQ    (modeArr[m]),
      .cmpQ     (cmpArr[m]),
      .flagQ    (modFlag[m]),
      .cexOut   (cexOut[m]),
      .intReq   (intVec[m])
    );
  end

  assign intReq  = |intVec;
  assign ovfFlag = ovfQ;

  always_comb begin
    statRd              = '0;
    statRd[NUM_MOD-1:0] = modFlag;
    statRd[OVF_BIT]     = ovfQ;
  end

  always_comb begin
    rdData = '0;
    if (strobes.selGlobal) begin
      unique case (strobes.field)
        2'd0: rdData = ctrlReg;
        2'd1: rdData = cntQ[DATA_W-1:0];
        2'd2: rdData = cntQ[CNT_W-1:DATA_W];
        2'd3: rdData = statRd;
      endcase
    end else if (strobes.selMod) begin
      for (int m = 0; m < NUM_MOD; m++) begin
        if (strobes.modSel == MOD_SEL_W'(m)) begin
          unique case (strobes.field)
            2'd0: rdData = DATA_W'(modeArr[m]);
            2'd1: rdData = cmpArr[m][DATA_W-1:0];
            2'd2: rdData = cmpArr[m][CNT_W-1:DATA_W];
            2'd3: rdData = '0;
          endcase
        end
      end
    end
  end

  // R3: without a tick or a write the counter does not move
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !cntWr) |=> $stable(cntQ));
  // R4: a tick advances the counter by exactly one
  p_cnt_inc_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !cntWr) |=> (cntQ == CNT_W'($past(cntQ) + 1'b1)));
  // R4: overflow is sticky until cleared
  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ovfQ && !(strobes.wrStat && wrData[OVF_BIT])) |=> ovfQ);
endmodule

// File: rtl/cap_cmp_array.sv
module cap_cmp_array
  import cca_pkg::*;
#(
  parameter int NUM_MOD = 5,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               idleMode,
  input  logic               tmr0Ovf,
  input  logic               extCount,
  input  logic [NUM_MOD-1:0] capIn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_MOD-1:0] cexOut,
  output logic [NUM_MOD-1:0] modFlag,
  output logic               ovfFlag,
  output logic               intReq
);
  ccaStrobeT          strobes;
  logic [NUM_MOD-1:0] capRise;
  logic [NUM_MOD-1:0] capFall;
  logic [DATA_W-1:0]  ctrlReg;

  cca_ctrl #(.NUM_MOD(NUM_MOD), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .idleMode (idleMode),
    .tmr0Ovf  (tmr0Ovf),
    .extCount (extCount),
    .capIn    (capIn),
    .wrEn     (wrEn),
    .addr     (addr),
    .wrData   (wrData),
    .strobes  (strobes),
    .capRise  (capRise),
    .capFall  (capFall),
    .ctrlReg  (ctrlReg)
  );

  cca_datapath #(.NUM_MOD(NUM_MOD), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (wrData),
    .capRise (capRise),
    .capFall (capFall),
    .ctrlReg (ctrlReg),
    .rdData  (rdData),
    .cexOut  (cexOut),
    .modFlag (modFlag),
    .ovfFlag (ovfFlag),
    .intReq  (intReq)
  );
endmodule

// File: tb/cap_cmp_array_bench.sv
module cap_cmp_array_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_MOD    = 5;
  localparam int ADDR_W     = 6;

  logic               clk = 1'b0;
  logic               rstN;
  logic               idleMode;
  logic               tmr0Ovf;
  logic               extCount;
  logic [NUM_MOD-1:0] capIn;
  logic               wrEn;
  logic [ADDR_W-1:0]  addr;
  logic [7:0]         wrData;
  logic [7:0]         rdData;
  logic [NUM_MOD-1:0] cexOut;
  logic [NUM_MOD-1:0] modFlag;
  logic               ovfFlag;
  logic               intReq;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cap_cmp_array u_cap_cmp_array (
    .clk(clk), .rstN(rstN), .idleMode(idleMode), .tmr0Ovf(tmr0Ovf),
    .extCount(extCount), .capIn(capIn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .cexOut(cexOut), .modFlag(modFlag),
    .ovfFlag(ovfFlag), .intReq(intReq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic tmrPulse();
    @(negedge clk);
    tmr0Ovf = 1'b1;
    @(negedge clk);
    tmr0Ovf = 1'b0;
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setCnt(input logic [15:0] v);
    regWrite(6'd1, v[7:0]);
    regWrite(6'd2, v[15:8]);
  endtask

  task automatic testReset();
    logic [7:0] d;
    regRead(6'd1, d); check("R1 cnt lo", 16'(d), 16'h0);
    regRead(6'd2, d); check("R1 cnt hi", 16'(d), 16'h0);
    regRead(6'd3, d); check("R1 status", 16'(d), 16'h0);
    regRead(6'd4, d); check("R1 mode0", 16'(d), 16'h0);
    regRead(6'd5, d); check("R1 cmp0 lo", 16'(d), 16'h0);
    check("R1 pins", 16'({cexOut, modFlag, ovfFlag, intReq}), 16'h0);
  endtask

  task automatic testReadback();
    logic [7:0] d;
    regWrite(6'd0, 8'h0A);
    regRead(6'd0, d); check("R12 ctrl", 16'(d), 16'h0A);
    regWrite(6'd12, 8'hD5);
    regRead(6'd12, d); check("R12 mode bit7", 16'(d), 16'h55);
    regWrite(6'd12, 8'h00);
    regWrite(6'd0, 8'h00);
  endtask

  task automatic testDivSources();
    logic [7:0] d;
    setCnt(16'h0000);
    regWrite(6'd0, 8'h01);
    repeat (120) @(posedge clk);
    @(negedge clk);
    regRead(6'd1, d); check("R2 div12", 16'(d), 16'd10);
    regWrite(6'd0, 8'h00);
    setCnt(16'h0000);
    regWrite(6'd0, 8'h05);
    repeat (40) @(posedge clk);
    @(negedge clk);
    regRead(6'd1, d); check("R2 div4", 16'(d), 16'd10);
    regWrite(6'd0, 8'h00);
  endtask

  task automatic testExtSource();
    logic [7:0] d;
    setCnt(16'h0000);
    regWrite(6'd0, 8'h0D);
    for (int i = 0; i < 5; i++) begin
      extCount = 1'b1; waitNeg(4);
      extCount = 1'b0; waitNeg(4);
    end
    regRead(6'd1, d); check("R2 ext edges", 16'(d), 16'd5);
    regWrite(6'd0, 8'h00);
  endtask

  task automatic testIdleRun();
    logic [7:0] d;
    setCnt(16'h0000);
    regWrite(6'd0, 8'h0B);
    idleMode = 1'b1;
    for (int i = 0; i < 3; i++) tmrPulse();
    regRead(6'd1, d); check("R3 idle stop", 16'(d), 16'd0);
    regWrite(6'd0, 8'h09);
    for (int i = 0; i < 3; i++) tmrPulse();
    regRead(6'd1, d); check("R3 idle run", 16'(d), 16'd3);
    idleMode = 1'b0;
    regWrite(6'd0, 8'h08);
    tmrPulse();
    regRead(6'd1, d); check("R3 run off", 16'(d), 16'd3);
  endtask

  task automatic testOverflow();
    logic [7:0] d;
    regWrite(6'd0, 8'h08);
    setCnt(16'hFFFF);
    regWrite(6'd0, 8'h09);
    tmrPulse();
    check("R4 ovf set", 16'(ovfFlag), 16'h1);
    regRead(6'd2, d); check("R4 wrap hi", 16'(d), 16'h00);
    tmrPulse();
    check("R4 ovf sticky", 16'(ovfFlag), 16'h1);
    regWrite(6'd3, 8'h00);
    check("R4 zero write keeps", 16'(ovfFlag), 16'h1);
    regWrite(6'd3, 8'h80);
    check("R4 ovf cleared", 16'(ovfFlag), 16'h0);
    regWrite(6'd0, 8'h08);
  endtask

  task automatic testCapture();
    logic [7:0] lo, hi;
    regWrite(6'd0, 8'h00);
    setCnt(16'h1234);
    regWrite(6'd8, 8'h50);
    capIn[1] = 1'b1; waitNeg(5);
    regRead(6'd9, lo); regRead(6'd10, hi);
    check("R5 rise capture", {hi, lo}, 16'h1234);
    check("R5 rise flag", 16'(modFlag[1]), 16'h1);
    check("R10 int on", 16'(intReq), 16'h1);
    regWrite(6'd3, 8'h02);
    check("R9 flag clear", 16'(modFlag[1]), 16'h0);
    check("R10 int off", 16'(intReq), 16'h0);
    setCnt(16'h5678);
    capIn[1] = 1'b0; waitNeg(5);
    regRead(6'd9, lo); regRead(6'd10, hi);
    check("R5 fall ignored", {hi, lo}, 16'h1234);
    check("R5 fall no flag", 16'(modFlag[1]), 16'h0);
    regWrite(6'd8, 8'h20);
    capIn[1] = 1'b1; waitNeg(5);
    check("R5 rise ignored", 16'(modFlag[1]), 16'h0);
    capIn[1] = 1'b0; waitNeg(5);
    regRead(6'd9, lo); regRead(6'd10, hi);
    check("R5 fall capture", {hi, lo}, 16'h5678);
    check("R10 flag without enable", 16'({modFlag[1], intReq}), 16'b10);
    regWrite(6'd3, 8'h00);
    check("R9 zero write keeps", 16'(modFlag[1]), 16'h1);
    regWrite(6'd3, 8'h02);
    regWrite(6'd8, 8'h00);
  endtask

  task automatic testMatchToggle();
    logic [7:0] d;
    regWrite(6'd0, 8'h08);
    setCnt(16'h1230);
    regWrite(6'd4, 8'h07);
    regWrite(6'd5, 8'h34);
    regRead(6'd4, d); check("R11 lo write disarms", 16'(d), 16'h06);
    regWrite(6'd6, 8'h12);
    regRead(6'd4, d); check("R11 hi write arms", 16'(d), 16'h07);
    regWrite(6'd0, 8'h09);
    for (int i = 0; i < 3; i++) tmrPulse();
    check("R6 no early flag", 16'(modFlag[0]), 16'h0);
    tmrPulse();
    @(negedge clk);
    check("R6 match flag", 16'(modFlag[0]), 16'h1);
    check("R7 toggle high", 16'(cexOut[0]), 16'h1);
    tmrPulse(); @(negedge clk);
    check("R7 no toggle off match", 16'(cexOut[0]), 16'h1);
    regWrite(6'd3, 8'h01);
    setCnt(16'h1233);
    tmrPulse(); @(negedge clk);
    check("R7 toggle low", 16'(cexOut[0]), 16'h0);
    check("R6 match again", 16'(modFlag[0]), 16'h1);
    regWrite(6'd3, 8'h01);
    regWrite(6'd4, 8'h01);
    setCnt(16'h1233);
    tmrPulse(); @(negedge clk);
    check("R6 match bit off", 16'({modFlag[0], cexOut[0]}), 16'h0);
    regWrite(6'd4, 8'h00);
    regWrite(6'd0, 8'h08);
  endtask

  task automatic testPwm();
    logic [7:0] d;
    regWrite(6'd0, 8'h08);
    regWrite(6'd17, 8'h40);
    regWrite(6'd18, 8'h40);
    regWrite(6'd16, 8'h09);
    setCnt(16'h003F);
    check("R8 below threshold", 16'(cexOut[3]), 16'h0);
    regWrite(6'd0, 8'h09);
    tmrPulse();
    check("R8 at threshold", 16'(cexOut[3]), 16'h1);
    regWrite(6'd18, 8'h80);
    regRead(6'd17, d); check("R8 no early reload", 16'(d), 16'h40);
    regWrite(6'd1, 8'hFE);
    tmrPulse();
    check("R8 above old duty", 16'(cexOut[3]), 16'h1);
    tmrPulse();
    regRead(6'd17, d); check("R8 reload", 16'(d), 16'h80);
    check("R8 after rollover", 16'(cexOut[3]), 16'h0);
    regWrite(6'd1, 8'h90);
    check("R8 new duty high", 16'(cexOut[3]), 16'h1);
    regWrite(6'd1, 8'h7F);
    check("R8 new duty low", 16'(cexOut[3]), 16'h0);
    check("R8 no flag", 16'(modFlag[3]), 16'h0);
    regWrite(6'd0, 8'h08);
  endtask

  initial begin
    rstN = 1'b0; idleMode = 1'b0; tmr0Ovf = 1'b0; extCount = 1'b0;
    capIn = '0; wrEn = 1'b0; addr = '0; wrData = '0;
    waitNeg(4);
    rstN = 1'b1;
    waitNeg(1);
    testReset();
    testReadback();
    testDivSources();
    testExtSource();
    testIdleRun();
    testOverflow();
    testCapture();
    testMatchToggle();
    testPwm();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule